// File: doc/BRIEF.md
# Fourteen-Channel 8-Bit PWM DAC Bank

The block turns fourteen 8-bit duty codes into fourteen pulse-width modulated outputs for external RC filtering. Each channel's code is held in its own register that software writes and reads over a small synchronous register port. Every channel compares its code against one shared period counter, so all outputs begin a period together at count zero and each stays high while the count is still below its code.

The counter advances on a PWM tick. The core clock `clk` runs at twice the base rate; with `fast_clk_en` low the counter advances on every second `clk` cycle (base rate), with it high on every cycle (double rate). `short_period` selects either a 256-tick period or a 253-tick period. In the short period the three top codes never meet the counter, so they hold the output high, while in the long period code FFh still leaves one low tick per period. Outputs model an open-drain pin: 1 means released (pulled high externally), 0 means driven low.

A code written to a register is staged and only copied into the channel's compare value when the counter wraps, so a period in progress is never cut short or stretched.

Top module: `pwm_dac_bank`

## Requirements
- R1: Channels 0 to 13 sit at register addresses 0 to 13; a write with `wr_en` high stores `wr_data` at the next rising edge and `rd_data` returns the stored code of `rd_addr` combinationally. Writes to addresses 14 and 15 change nothing, and reads there return 00h.
- R2: After reset every register reads 80h, the counter is 0 and every output is 1.
- R3: With `fast_clk_en`=0 the counter advances once per two `clk` cycles; with `fast_clk_en`=1 it advances every `clk` cycle.
- R4: With `short_period`=0 the counter runs 0 to 255 (256 ticks); with `short_period`=1 it runs 0 to 252 (253 ticks) and then returns to 0.
- R5: A channel output is 1 while the counter is below its active code and 0 otherwise; all channels share the same counter.
- R6: Code 00h gives a constant 0 output in both period modes.
- R7: In the 253-tick mode codes FDh, FEh and FFh give a constant 1 output.
- R8: In the 256-tick mode code FFh gives exactly one low tick in every period.
- R9: A newly written code becomes active only when the counter wraps to 0; a write accepted on the same edge as the wrap is active for the period beginning at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the base PWM rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_clk_en | input | 1 | 1: counter ticks every clk; 0: every second clk |
| short_period | input | 1 | 1: 253-tick period; 0: 256-tick period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Stored code at rd_addr, 00h for unused addresses |
| pwm_hi | output | 14 | Per-channel output, 1 = released high, 0 = driven low |

## Verification
The register write path and the counter wrap can land on the same clock edge, and that is where a staging design most easily loses or delays a code. The bench watches its own model of the counter, places a write on the exact falling edge before a wrap edge, and then counts the high cycles of the written channel over the following period, which must match the new code and not the old one. A write placed in mid-period is judged the other way: the rest of that period must still show the old code.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  parameter int DUTY_W = 8;

  typedef logic [DUTY_W-1:0] duty_t;

  // Highest counter value of a period in the selected mode.
  function automatic duty_t period_last(input logic short_mode);
    duty_t full_top;
    full_top = '1;
    return short_mode ? (full_top - duty_t'(3)) : full_top;
  endfunction

  // Output level for one channel: high while the count is below the code.
  function automatic logic pwm_level(input duty_t count, input duty_t code);
    return count < code;
  endfunction

  // Counter wraps on a tick that finds it at (or past) the period top.
  function automatic logic wrap_due(input logic tick, input duty_t count,
                                    input duty_t top);
    return tick && (count >= top);
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fast_clk_en,
  input  logic  short_period,
  output duty_t count,
  output logic  tick,
  output logic  wrap
);

  logic  phase_q;
  duty_t top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign tick = fast_clk_en | phase_q;
  assign top  = period_last(short_period);
  assign wrap = wrap_due(tick, count, top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (tick) count <= count + duty_t'(1);
  end

  // R3: at base rate a tick is never followed directly by another one
  a_r3_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast_clk_en) |=> (!tick || fast_clk_en));

  // R4: a wrap always leaves the counter at zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));

  // R4: without a tick the counter holds
  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs
  import pwm_bank_pkg::*;
#(
  parameter int    NUM_CH    = 14,
  parameter int    AW        = 4,
  parameter duty_t RESET_VAL = duty_t'(8'h80)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  duty_t                        wr_data,
  input  logic [AW-1:0]                rd_addr,
  output duty_t                        rd_data,
  output logic [NUM_CH-1:0][DUTY_W-1:0] duty_next
);

  localparam logic [AW-1:0] LAST_IDX = AW'(NUM_CH - 1);

  logic [NUM_CH-1:0][DUTY_W-1:0] duty_q;
  logic [NUM_CH-1:0]             sel;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    assign sel[i]       = wr_en && (wr_addr == AW'(i));
    assign duty_next[i] = sel[i] ? wr_data : duty_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q[i] <= RESET_VAL;
      else        duty_q[i] <= duty_next[i];
    end

    // R1: a selected write is stored on the next edge
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      sel[i] |=> (duty_q[i] == $past(wr_data)));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_addr == AW'(i)) rd_data = duty_q[i];
    end
  end

  // R1: writes beyond the last channel leave every register untouched
  a_r1_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > LAST_IDX)) |=> $stable(duty_q));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter duty_t RESET_VAL = duty_t'(8'h80)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  duty_t count,
  input  logic  wrap,
  input  duty_t load_val,
  output logic  level
);

  duty_t duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_act <= RESET_VAL;
    else if (wrap) duty_act <= load_val;
  end

  assign level = pwm_level(count, duty_act);

  // R9: the active code moves only on a wrap
  a_r9_active_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_act));

  // R9: on a wrap the staged (or same-edge written) code is taken
  a_r9_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (duty_act == $past(load_val)));

  // R6: a zero code never releases the output
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !level);

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_bank_pkg::*;
#(
  parameter int    NUM_CH     = 14,
  parameter duty_t RESET_DUTY = duty_t'(8'h80)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_clk_en,
  input  logic              short_period,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_CH-1:0] pwm_hi
);

  localparam int AW = 4;

  duty_t                         count;
  logic                          tick;
  logic                          wrap;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty_next;

  pwm_timebase u_timebase (
    .clk          (clk),
    .rst_n        (rst_n),
    .fast_clk_en  (fast_clk_en),
    .short_period (short_period),
    .count        (count),
    .tick         (tick),
    .wrap         (wrap)
  );

  pwm_duty_regs #(
    .NUM_CH    (NUM_CH),
    .AW        (AW),
    .RESET_VAL (RESET_DUTY)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .duty_next (duty_next)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel #(
      .RESET_VAL (RESET_DUTY)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (count),
      .wrap     (wrap),
      .load_val (duty_next[i]),
      .level    (pwm_hi[i])
    );
  end

  // R5: all channels see a period start together, a zero count releases every nonzero code
  a_r5_aligned_start: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ((count == '0) && (tick || !tick)));

  // R7: in the short mode the counter stays below FDh once a full period has passed
  a_r7_short_top: assert property (@(posedge clk) disable iff (!rst_n)
    (short_period && $past(short_period) && $past(wrap)) |-> (count < duty_t'(8'hFD)));

endmodule

// File: tb/pwm_dac_bank_bench.sv
`timescale 1ns/1ps
module pwm_dac_bank_bench;

  localparam int NCH = 14;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           fast_clk_en = 1'b0;
  logic           short_period = 1'b0;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [3:0]     rd_addr = '0;
  logic [7:0]     rd_data;
  logic [NCH-1:0] pwm_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pwm_dac_bank u_pwm_dac_bank (
    .clk(clk), .rst_n(rst_n), .fast_clk_en(fast_clk_en),
    .short_period(short_period), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_hi(pwm_hi)
  );

  // Reference model built from the requirements
  int             mcnt = 0;
  bit             mphase = 0;
  bit             mwrapped = 0;
  logic [7:0]     mact  [NCH];
  logic [7:0]     mshad [NCH];
  logic [NCH-1:0] exp_q [$];

  always @(posedge clk) begin
    logic [NCH-1:0] e;
    bit tk;
    int top;
    if (!rst_n) begin
      mcnt = 0; mphase = 0; mwrapped = 0;
      for (int i = 0; i < NCH; i++) begin mact[i] = 8'h80; mshad[i] = 8'h80; end
    end else begin
      tk  = fast_clk_en | mphase;
      top = short_period ? 252 : 255;
      if (wr_en && wr_addr < NCH) mshad[wr_addr] = wr_data;
      mwrapped = tk && (mcnt >= top);
      if (mwrapped) begin
        mcnt = 0;
        for (int i = 0; i < NCH; i++) mact[i] = mshad[i];
      end else if (tk) mcnt = mcnt + 1;
      mphase = !mphase;
    end
    for (int i = 0; i < NCH; i++) e[i] = (mcnt < mact[i]);
    exp_q.push_back(e);
  end

  // Monitor: one comparison per cycle (R5)
  always @(negedge clk) begin
    logic [NCH-1:0] e;
    if (!done && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (pwm_hi !== e) begin
        fails++;
        $display("FAIL R5 cycle compare: pwm_hi actual %h expected %h", pwm_hi, e);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input string tag, input int a, input int exp);
    rd_addr = 4'(a);
    #1;
    check(tag, int'(rd_data), exp);
  endtask

  int hi [NCH];
  int plen;

  // Count high cycles per channel over one full period
  task automatic measure();
    do @(negedge clk); while (!mwrapped);
    plen = 0;
    for (int i = 0; i < NCH; i++) hi[i] = 0;
    do begin
      plen++;
      for (int i = 0; i < NCH; i++) hi[i] += int'(pwm_hi[i]);
      @(negedge clk);
    end while (!mwrapped);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset values
    for (int i = 0; i < NCH; i++) read_check("R2 reset code", i, 8'h80);
    check("R2 outputs high after reset", int'(pwm_hi), (1 << NCH) - 1);

    // R1: write, readback, unused addresses
    write_reg(5, 8'h3C);
    read_check("R1 readback ch5", 5, 8'h3C);
    write_reg(14, 8'h11);
    write_reg(15, 8'h22);
    read_check("R1 read unused addr 14", 14, 0);
    read_check("R1 read unused addr 15", 15, 0);
    for (int i = 0; i < NCH; i++) read_check("R1 unused write ignored", i, (i == 5) ? 8'h3C : 8'h80);

    // Base rate, 256-tick period
    write_reg(0, 8'h00);
    write_reg(1, 8'hFF);
    write_reg(2, 8'h40);
    write_reg(3, 8'hFD);
    write_reg(4, 8'hFE);
    measure();
    measure();
    check("R3 R4 base rate 256 period length", plen, 512);
    check("R6 zero code long mode", hi[0], 0);
    check("R8 FF one low tick long mode", hi[1], 510);
    check("R5 code 40h high time", hi[2], 128);
    check("R5 code FDh long mode", hi[3], 506);
    check("R5 code 3Ch high time", hi[5], 120);

    // 253-tick period
    short_period = 1'b1;
    measure();
    measure();
    check("R4 short period length", plen, 506);
    check("R6 zero code short mode", hi[0], 0);
    check("R7 FF steady high", hi[1], plen);
    check("R7 FD steady high", hi[3], plen);
    check("R7 FE steady high", hi[4], plen);

    // Double rate
    fast_clk_en = 1'b1;
    measure();
    measure();
    check("R3 double rate short period length", plen, 253);
    check("R5 code 40h double rate", hi[2], 64);

    // R9: mid-period write keeps the old code until the wrap
    do @(negedge clk); while (!mwrapped);
    plen = 0; hi[2] = 0;
    do begin
      plen++;
      hi[2] += int'(pwm_hi[2]);
      if (plen == 10) begin wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'hC0; end
      if (plen == 11) wr_en = 1'b0;
      @(negedge clk);
    end while (!mwrapped);
    check("R9 mid-period write deferred", hi[2], 64);
    plen = 0; hi[2] = 0;
    do begin
      plen++;
      hi[2] += int'(pwm_hi[2]);
      @(negedge clk);
    end while (!mwrapped);
    check("R9 new code after wrap", hi[2], 192);

    // R9: write on the same edge as the wrap
    while (!((fast_clk_en | mphase) && mcnt >= (short_period ? 252 : 255))) @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h20;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 wrap seen on collision edge", int'(mwrapped), 1);
    plen = 0; hi[2] = 0;
    do begin
      plen++;
      hi[2] += int'(pwm_hi[2]);
      @(negedge clk);
    end while (!mwrapped);
    check("R9 same-edge write active at once", hi[2], 32);

    // Long mode at double rate, FF still pulses low
    short_period = 1'b0;
    measure();
    measure();
    check("R4 long period double rate", plen, 256);
    check("R8 FF one low tick double rate", hi[1], 255);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule